// File: doc/BRIEF.md
# Add-Compare-Branch Loop Execution Unit

This unit is the execute stage of an integer loop-control instruction. Each issued operation carries an opcode that picks the operand size (byte, word or longword), a limit, an addend and an index, all signed. It also carries a branch displacement and the current fall-through program counter. The unit adds the addend to the index and writes the sum back into the index destination. It then compares the updated index with the limit. The direction of that comparison depends on the sign of the addend, so one instruction closes both counting-up and counting-down loops.

All work for an operation happens in one combinational pass. The results go through a single register stage. The unit returns the redirect decision, the next program counter, the write-back value, the N/Z/V/C condition codes and an integer-overflow trap request. When the sum overflows, the wrapped value still decides the branch. The trap request comes out together with a next PC that already holds the branch outcome, so the exception handler sees the loop target when the branch was taken.

Top module: `loop_acb_unit`

## Requirements
- R1: Opcode 0x9D selects byte size, 0x3D selects word size and 0xF1 selects longword size. Any other opcode is treated as illegal: branch not taken, `next_pc` equal to `pc_in`, `result` equal to `index_op`, N, Z, V and `trap_req` cleared, and C equal to `c_in`.
- R2: `result` takes the sum of the low size-width bits of `index_op` and `addend_op`, truncated to that width. Bits of `index_op` above the active size pass through unchanged. Bits of `limit_op` and `addend_op` above the active size have no effect.
- R3: If the addend at the active size is zero or positive, the branch is taken exactly when the new index is less than or equal to the limit. Both values are sign-extended from the active size.
- R4: If the addend at the active size is negative, the branch is taken exactly when the new index is greater than or equal to the limit. Both values are sign-extended from the active size.
- R5: On a taken branch, `next_pc` = `pc_in` + the sign-extended displacement. The displacement is `disp_op[7:0]` when `disp_word` is 0 and `disp_op[15:0]` when it is 1. On a branch that is not taken, `next_pc` = `pc_in`.
- R6: N is set when the new index at the active size is negative. Z is set when it is zero.
- R7: Signed overflow at the active size sets V and `trap_req`. The compare in R3 and R4 still uses the wrapped value.
- R8: C is always set equal to `c_in`.
- R9: `done` pulses one cycle after each `in_valid` cycle. While `in_valid` is low, the result outputs keep their last values.
- R10: While `rst_n` is low, all outputs clear to zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| opcode | input | 8 | Selects operand size |
| limit_op | input | DATA_W | Loop limit |
| addend_op | input | DATA_W | Step added to the index |
| index_op | input | DATA_W | Current index value |
| disp_op | input | DISP_W | Branch displacement |
| disp_word | input | 1 | 1: 16-bit displacement, 0: 8-bit |
| pc_in | input | PC_W | Fall-through program counter |
| c_in | input | 1 | Incoming carry flag |
| done | output | 1 | Results valid |
| branch_taken | output | 1 | Loop branch redirects the PC |
| next_pc | output | PC_W | Next program counter |
| result | output | DATA_W | Index write-back value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (passed through) |
| trap_req | output | 1 | Integer-overflow trap request |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 32-bit PC and a 16-bit displacement. With these settings all three size lanes exist, including the full-width one. For each size, it sweeps the full cross-product of eight boundary values for limit, addend and index: both extremes, their neighbours, -1, 0, 1 and 2. This reaches every overflow direction, equality at the limit and both compare senses. The bits above the active size are filled with junk, and the displacement width, the PC (including a value near wrap-around) and the incoming carry change from one operation to the next. Illegal opcodes, idle-cycle hold and reset are checked separately.

// File: rtl/acb_pkg.sv
// Package: shared types and opcode constants for the add-compare-branch unit.
// Assumes a datapath of at least 16 bits so that word operations fit.
package acb_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } acb_size_e;

    localparam logic [7:0] OPC_LOOP_BYTE = 8'h9D;
    localparam logic [7:0] OPC_LOOP_WORD = 8'h3D;
    localparam logic [7:0] OPC_LOOP_LONG = 8'hF1;

    localparam int NUM_LANES = 3;

    // Width in bits of lane g for a datapath of data_w bits.
    function automatic int lane_width(input int g, input int data_w);
        return (g == 0) ? 8 : (g == 1) ? 16 : data_w;
    endfunction

endpackage

// File: rtl/acb_size_decode.sv
// Module: acb_size_decode
// Maps the instruction opcode to an operand size. Unrecognized opcodes
// give SZ_NONE with legal low. Purely combinational.
module acb_size_decode
    import acb_pkg::*;
(
    input  logic [7:0] opcode,
    output acb_size_e  size,
    output logic       legal
);

    // Opcode to size lookup.
    always_comb begin
        unique case (opcode)
            OPC_LOOP_BYTE: size = SZ_BYTE;
            OPC_LOOP_WORD: size = SZ_WORD;
            OPC_LOOP_LONG: size = SZ_LONG;
            default:       size = SZ_NONE;
        endcase
        legal = (size != SZ_NONE);
    end

endmodule

// File: rtl/acb_sized_add.sv
// Module: acb_sized_add
// Adds addend to index in one lane per operand size and selects the lane
// for the active size. Outputs the merged write-back word (upper index bits
// kept), the sign-extended new index and limit, the addend sign and signed
// overflow at that size. Combinational. SZ_NONE returns the index unchanged.
module acb_sized_add
    import acb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acb_size_e          size,
    input  logic [DATA_W-1:0]  index_op,
    input  logic [DATA_W-1:0]  addend_op,
    input  logic [DATA_W-1:0]  limit_op,
    output logic [DATA_W-1:0]  wb_value,
    output logic [DATA_W-1:0]  new_idx_sx,
    output logic [DATA_W-1:0]  limit_sx,
    output logic               addend_neg,
    output logic               overflow
);

    logic [DATA_W-1:0] lane_wb   [NUM_LANES];
    logic [DATA_W-1:0] lane_sx   [NUM_LANES];
    logic [DATA_W-1:0] lane_lim  [NUM_LANES];
    logic              lane_neg  [NUM_LANES];
    logic              lane_ovf  [NUM_LANES];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = lane_width(g, DATA_W);
        localparam logic [DATA_W-1:0] LMASK =
            (LW >= DATA_W) ? {DATA_W{1'b1}} : DATA_W'((64'd1 << LW) - 64'd1);

        logic [LW-1:0] a_w;
        logic [LW-1:0] i_w;
        logic [LW-1:0] s_w;

        // Per-lane sum, sign extension, merge and overflow detection.
        always_comb begin
            a_w           = addend_op[LW-1:0];
            i_w           = index_op[LW-1:0];
            s_w           = a_w + i_w;
            lane_sx[g]    = DATA_W'($signed(s_w));
            lane_lim[g]   = DATA_W'($signed(limit_op[LW-1:0]));
            lane_neg[g]   = a_w[LW-1];
            lane_ovf[g]   = (a_w[LW-1] == i_w[LW-1]) && (s_w[LW-1] != a_w[LW-1]);
            lane_wb[g]    = (index_op & ~LMASK) | (DATA_W'(s_w) & LMASK);
        end
    end

    // Select the lane that matches the active size.
    always_comb begin
        if (size == SZ_NONE) begin
            wb_value   = index_op;
            new_idx_sx = '0;
            limit_sx   = '0;
            addend_neg = 1'b0;
            overflow   = 1'b0;
        end else begin
            wb_value   = lane_wb[size];
            new_idx_sx = lane_sx[size];
            limit_sx   = lane_lim[size];
            addend_neg = lane_neg[size];
            overflow   = lane_ovf[size];
        end
    end

endmodule

// File: rtl/acb_branch_resolve.sv
// Module: acb_branch_resolve
// Chooses the compare direction from the addend sign, decides whether the
// loop branch is taken, and forms the next PC from the sign-extended
// displacement. Assumes the new index and limit arrive already
// sign-extended to full width. Combinational.
module acb_branch_resolve #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int DISP_W = 16
) (
    input  logic              legal,
    input  logic [DATA_W-1:0] new_idx_sx,
    input  logic [DATA_W-1:0] limit_sx,
    input  logic              addend_neg,
    input  logic [DISP_W-1:0] disp_op,
    input  logic              disp_word,
    input  logic [PC_W-1:0]   pc_in,
    output logic              taken,
    output logic [PC_W-1:0]   target_pc
);

    logic [PC_W-1:0] disp_ext;

    // Direction-sensitive signed compare.
    always_comb begin
        if (!legal)
            taken = 1'b0;
        else if (addend_neg)
            taken = $signed(new_idx_sx) >= $signed(limit_sx);
        else
            taken = $signed(new_idx_sx) <= $signed(limit_sx);
    end

    // Displacement extension and PC selection.
    always_comb begin
        disp_ext  = disp_word ? PC_W'($signed(disp_op))
                              : PC_W'($signed(disp_op[7:0]));
        target_pc = taken ? (pc_in + disp_ext) : pc_in;
    end

endmodule

// File: rtl/loop_acb_unit.sv
// Module: loop_acb_unit (top)
// Execute-stage unit for the add-compare-branch loop instruction. Decodes
// the size, adds and compares, then registers branch, next PC, write-back,
// flags and the overflow trap. done pulses one cycle after in_valid.
// Assumes DATA_W >= 16 and DISP_W >= 16. Synchronous active-low reset.
module loop_acb_unit
    import acb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] limit_op,
    input  logic [DATA_W-1:0] addend_op,
    input  logic [DATA_W-1:0] index_op,
    input  logic [DISP_W-1:0] disp_op,
    input  logic              disp_word,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              c_in,
    output logic              done,
    output logic              branch_taken,
    output logic [PC_W-1:0]   next_pc,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              trap_req
);

    acb_size_e         size;
    logic              legal;
    logic [DATA_W-1:0] wb_value;
    logic [DATA_W-1:0] new_idx_sx;
    logic [DATA_W-1:0] limit_sx;
    logic              addend_neg;
    logic              overflow;
    logic              taken;
    logic [PC_W-1:0]   target_pc;

    acb_size_decode u_dec (
        .opcode (opcode),
        .size   (size),
        .legal  (legal)
    );

    acb_sized_add #(.DATA_W(DATA_W)) u_add (
        .size       (size),
        .index_op   (index_op),
        .addend_op  (addend_op),
        .limit_op   (limit_op),
        .wb_value   (wb_value),
        .new_idx_sx (new_idx_sx),
        .limit_sx   (limit_sx),
        .addend_neg (addend_neg),
        .overflow   (overflow)
    );

    acb_branch_resolve #(.DATA_W(DATA_W), .PC_W(PC_W), .DISP_W(DISP_W)) u_br (
        .legal      (legal),
        .new_idx_sx (new_idx_sx),
        .limit_sx   (limit_sx),
        .addend_neg (addend_neg),
        .disp_op    (disp_op),
        .disp_word  (disp_word),
        .pc_in      (pc_in),
        .taken      (taken),
        .target_pc  (target_pc)
    );

    // Output stage: done follows in_valid; results load only on in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            branch_taken <= 1'b0;
            next_pc      <= '0;
            result       <= '0;
            flag_n       <= 1'b0;
            flag_z       <= 1'b0;
            flag_v       <= 1'b0;
            flag_c       <= 1'b0;
            trap_req     <= 1'b0;
        end else begin
            done <= in_valid;
            if (in_valid) begin
                branch_taken <= taken;
                next_pc      <= target_pc;
                result       <= wb_value;
                flag_n       <= legal && new_idx_sx[DATA_W-1];
                flag_z       <= legal && (new_idx_sx == '0);
                flag_v       <= overflow;
                flag_c       <= c_in;
                trap_req     <= overflow;
            end
        end
    end

endmodule

// File: rtl/acb_checker.sv
// Module: acb_checker
// Assertion checker for loop_acb_unit. It is attached through the bind at
// the end of this file and only observes the unit's ports.
module acb_checker #(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int DISP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] limit_op,
    input logic [DATA_W-1:0] addend_op,
    input logic [DATA_W-1:0] index_op,
    input logic [DISP_W-1:0] disp_op,
    input logic              disp_word,
    input logic [PC_W-1:0]   pc_in,
    input logic              c_in,
    input logic              done,
    input logic              branch_taken,
    input logic [PC_W-1:0]   next_pc,
    input logic [DATA_W-1:0] result,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c,
    input logic              trap_req
);

    logic opc_bad;
    assign opc_bad = (opcode != 8'h9D) && (opcode != 8'h3D) && (opcode != 8'hF1);

    a_r1_illegal_passive: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && opc_bad |=> !branch_taken && !trap_req && !flag_v
                                && result == $past(index_op));

    a_r5_fallthrough_pc: assert property (@(posedge clk) disable iff (!rst_n)
        done && !branch_taken |-> next_pc == $past(pc_in));

    a_r6_nz_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(flag_n && flag_z));

    a_r7_trap_with_v: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> trap_req == flag_v);

    a_r8_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> flag_c == $past(c_in));

    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(next_pc) && $stable(branch_taken));

    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !done && !branch_taken && !trap_req && result == '0);

endmodule

bind loop_acb_unit acb_checker #(.DATA_W(DATA_W), .PC_W(PC_W), .DISP_W(DISP_W)) chk_i (.*);

// File: tb/loop_acb_unit_tb.sv
// Self-checking bench for loop_acb_unit: boundary cross-product per size,
// illegal opcodes, idle hold and reset.
module loop_acb_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 32;
    localparam int PC_W   = 32;
    localparam int DISP_W = 16;
    localparam int WATCHDOG_CYCLES = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        opcode = '0;
    logic [DATA_W-1:0] limit_op = '0;
    logic [DATA_W-1:0] addend_op = '0;
    logic [DATA_W-1:0] index_op = '0;
    logic [DISP_W-1:0] disp_op = '0;
    logic              disp_word = 1'b0;
    logic [PC_W-1:0]   pc_in = '0;
    logic              c_in = 1'b0;
    logic              done;
    logic              branch_taken;
    logic [PC_W-1:0]   next_pc;
    logic [DATA_W-1:0] result;
    logic              flag_n, flag_z, flag_v, flag_c, trap_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] last_res;
    logic [31:0] last_pc;
    logic        last_taken;

    loop_acb_unit #(.DATA_W(DATA_W), .PC_W(PC_W), .DISP_W(DISP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .limit_op(limit_op), .addend_op(addend_op), .index_op(index_op),
        .disp_op(disp_op), .disp_word(disp_word), .pc_in(pc_in), .c_in(c_in),
        .done(done), .branch_taken(branch_taken), .next_pc(next_pc),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .trap_req(trap_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG_CYCLES) begin
                checks++;
                errors++;
                $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, WATCHDOG_CYCLES);
                finish_run();
            end
        end
    end

    // Sign-extend the low w bits of v.
    function automatic longint sxw(input logic [31:0] v, input int w);
        longint x;
        x = longint'(v) & ((64'd1 << w) - 64'd1);
        if (x >= longint'(64'd1 << (w - 1)))
            x = x - longint'(64'd1 << w);
        return x;
    endfunction

    function automatic int width_of(input logic [7:0] opc);
        case (opc)
            8'h9D:   return 8;
            8'h3D:   return 16;
            8'hF1:   return 32;
            default: return 0;
        endcase
    endfunction

    // Issue one operation, then check every output in the following cycle.
    task automatic run_op(input logic [7:0] opc, input logic [31:0] lim,
                          input logic [31:0] add, input logic [31:0] idx,
                          input logic [15:0] dsp, input logic dw,
                          input logic [31:0] pc, input logic cin);
        int w;
        longint si, sa, sl, tsum, wr, dx;
        logic [31:0] mask, e_res, e_pc;
        logic e_tk, e_n, e_z, e_v;
        @(negedge clk);
        opcode = opc; limit_op = lim; addend_op = add; index_op = idx;
        disp_op = dsp; disp_word = dw; pc_in = pc; c_in = cin; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        w = width_of(opc);
        if (w == 0) begin
            e_res = idx; e_tk = 1'b0; e_pc = pc; e_n = 1'b0; e_z = 1'b0; e_v = 1'b0;
        end else begin
            si = sxw(idx, w); sa = sxw(add, w); sl = sxw(lim, w);
            tsum = si + sa;
            wr = sxw(tsum[31:0], w);
            e_v = (tsum != wr);
            mask = (w == 32) ? 32'hFFFF_FFFF : 32'((64'd1 << w) - 64'd1);
            e_res = (idx & ~mask) | (tsum[31:0] & mask);
            e_tk = (sa >= 0) ? (wr <= sl) : (wr >= sl);
            dx = dw ? sxw({16'h0, dsp}, 16) : sxw({24'h0, dsp[7:0]}, 8);
            e_pc = e_tk ? 32'(longint'(pc) + dx) : pc;
            e_n = (wr < 0);
            e_z = (wr == 0);
        end
        chk("R9 done", 64'(done), 64'(1'b1));
        chk("R2 result", 64'(result), 64'(e_res));
        chk((sa < 0 && w != 0) ? "R4 taken" : "R3 taken", 64'(branch_taken), 64'(e_tk));
        chk("R5 next_pc", 64'(next_pc), 64'(e_pc));
        chk("R6 flags_nz", {62'h0, flag_n, flag_z}, {62'h0, e_n, e_z});
        chk("R7 overflow_v_trap", {62'h0, flag_v, trap_req}, {62'h0, e_v, e_v});
        chk("R8 carry", 64'(flag_c), 64'(cin));
        if (w == 0)
            chk("R1 illegal", {61'h0, branch_taken, flag_v, trap_req}, 64'h0);
        last_res = e_res; last_pc = e_pc; last_taken = e_tk;
    endtask

    initial begin
        logic [7:0] opcs [3];
        longint bnd [8];
        int k;
        opcs[0] = 8'h9D; opcs[1] = 8'h3D; opcs[2] = 8'hF1;
        k = 0;

        // R10: reset clears outputs.
        repeat (3) @(negedge clk);
        chk("R10 reset", {44'h0, done, branch_taken, trap_req, flag_n, flag_z, flag_v,
                          flag_c, 13'h0}, 64'h0);
        chk("R10 reset_data", {result, next_pc}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle_after_reset", 64'(done), 64'h0);

        // R2..R8: boundary cross-product for each legal size (R1 decode).
        for (int s = 0; s < 3; s++) begin
            int w = width_of(opcs[s]);
            longint mn = -(longint'(64'd1 << (w - 1)));
            longint mx = longint'(64'd1 << (w - 1)) - 1;
            bnd[0] = mn; bnd[1] = mn + 1; bnd[2] = -1; bnd[3] = 0;
            bnd[4] = 1;  bnd[5] = 2;      bnd[6] = mx - 1; bnd[7] = mx;
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    for (int c = 0; c < 8; c++) begin
                        logic [31:0] mask, junk_i, junk_a, junk_l, pcv;
                        mask = (w == 32) ? 32'hFFFF_FFFF : 32'((64'd1 << w) - 64'd1);
                        junk_i = 32'hA5C3_5A3C ^ 32'(k * 32'h0101_0101);
                        junk_a = 32'h5AF0_96E1 ^ 32'(k * 32'h0013_0017);
                        junk_l = 32'hC33C_0FF0 ^ 32'(k * 32'h0007_0301);
                        pcv = (k % 5 == 0) ? 32'hFFFF_FFF0 : 32'h1000_0000 + 32'(k * 4);
                        run_op(opcs[s],
                               (junk_l & ~mask) | (bnd[c][31:0] & mask),
                               (junk_a & ~mask) | (bnd[b][31:0] & mask),
                               (junk_i & ~mask) | (bnd[a][31:0] & mask),
                               16'(k * 16'h1357), k[0], pcv, k[1]);
                        k++;
                    end
                end
            end
        end

        // R1: unrecognized opcodes leave everything passive.
        run_op(8'h00, 32'h0000_0010, 32'h1, 32'h5, 16'h0040, 1'b0, 32'h2000, 1'b1);
        run_op(8'hFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h8000, 1'b1, 32'h3000, 1'b0);
        run_op(8'h9C, 32'h10, 32'h1, 32'h2, 16'h0010, 1'b1, 32'h4000, 1'b1);

        // R9: idle cycle with changed inputs keeps outputs and drops done.
        run_op(8'h3D, 32'h0000_0100, 32'h0000_0001, 32'h0000_0010, 16'hFFF0, 1'b1, 32'h5000, 1'b0);
        opcode = 8'hF1; index_op = 32'h1234_5678; addend_op = 32'h1;
        limit_op = 32'h0; pc_in = 32'h9999_0000;
        @(negedge clk);
        chk("R9 idle_done", 64'(done), 64'h0);
        chk("R9 hold_result", 64'(result), 64'(last_res));
        chk("R9 hold_pc", 64'(next_pc), 64'(last_pc));
        chk("R9 hold_taken", 64'(branch_taken), 64'(last_taken));

        // R10: reset mid-run clears again.
        run_op(8'h9D, 32'h7F, 32'h7F, 32'h01, 16'h0005, 1'b0, 32'h6000, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset_again", {result, 28'h0, done, branch_taken, trap_req, flag_c}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule